// File: doc/BRIEF.md
# IPMB Fixed-Response Request Responder

This block sits between a byte-level I2C target front end and a byte-level I2C controller back end. Acting as target, it takes in one request frame written to it, keeps the header fields that the reply needs, and counts the bytes. When the write ends with a stop and the frame is long enough, it builds a ten-byte completion frame. That frame echoes the request's routing fields, carries a success completion code and has both of its checksums filled in. The block then asks for the bus, turns into a controller and writes the frame back to the requester.

Byte data moves on valid/ready pairs. On the target side, `tgt_wr_ready` is always high, so the front end is never held back. On the controller side, the block holds `ctl_valid`, `ctl_first` and `ctl_data` steady until `ctl_ready` accepts the item. It then waits for one acknowledge report on `ctl_ack_valid` before it offers the next item. Bus request, grant, stop and the overflow flag are plain level or pulse pins.

Top module: `ipmb_echo_responder`

## Requirements
- R1: A start-of-write pulse on `tgt_start_wr` sets the received byte count back to zero and clears `rx_overflow`. Every reply is built only from the bytes written after the most recent start-of-write.
- R2: Each cycle with `tgt_rd_req` high is answered in the next cycle with `tgt_rd_valid` high and `tgt_rd_data` equal to 0xFF.
- R3: A stop launches a reply only when at least `MIN_LEN` (default 5) bytes were received since the last start-of-write. Shorter frames raise no bus request.
- R4: After a launch, `ctl_bus_req` goes high and stays high. No item is offered on `ctl_valid` until `ctl_bus_grant` is seen.
- R5: The first item is flagged by `ctl_first`. It carries the 7-bit return address, which is request byte 2 shifted right by one, in `ctl_data[6:0]`, and `ctl_data[7]` is 0.
- R6: Reply byte 1 is the request's byte 0 with its upper six bits incremented (mod 64) and its two low bits cleared. Reply byte 2 is 0 minus (request byte 2 + reply byte 1), mod 256.
- R7: Reply byte 3 is `OWN_ADDR` (default 0x16). Byte 4 is request byte 3 with its two low bits cleared. Byte 5 is request byte 4. Bytes 6, 7 and 8 are 0x00, 0x55 and 0x00.
- R8: Reply byte 9 is 0 minus the mod-256 sum of bytes 0 to 8. In that sum, byte 0 is the unshifted request byte 2.
- R9: An acknowledge report with `ctl_ack_nack` high, on the address or on any data byte, ends the reply. No further item is offered, and `ctl_stop` pulses next.
- R10: `ctl_stop` pulses for one cycle after the last byte or after an abort, and `ctl_bus_req` is low in the following cycle. The next reply starts again from the address item.
- R11: While a reply is pending or in progress, target writes are still stored, but a stop starts no second reply. Once idle again, a bare stop replies from the stored frame.
- R12: Bytes written once `RX_DEPTH` (default 512) bytes are held are dropped. They set `rx_overflow`, which stays set until the next start-of-write.
- R13: While `ctl_valid` is high and `ctl_ready` is low, `ctl_valid`, `ctl_first` and `ctl_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_start_wr | input | 1 | Target addressed for write (pulse) |
| tgt_wr_valid | input | 1 | Written data byte valid |
| tgt_wr_data | input | 8 | Written data byte |
| tgt_wr_ready | output | 1 | Always high: written bytes never stalled |
| tgt_stop | input | 1 | Stop condition seen (pulse) |
| tgt_rd_req | input | 1 | Target read byte request |
| tgt_rd_valid | output | 1 | Read byte answer valid |
| tgt_rd_data | output | 8 | Read byte answer (0xFF) |
| rx_overflow | output | 1 | Write past receive depth since last start |
| ctl_bus_req | output | 1 | Controller bus request, held until release |
| ctl_bus_grant | input | 1 | Bus granted to this block |
| ctl_valid | output | 1 | Controller item valid |
| ctl_first | output | 1 | Item is the start-with-address |
| ctl_data | output | 8 | Address (bits 6:0) or data byte |
| ctl_ready | input | 1 | Controller accepts the item |
| ctl_ack_valid | input | 1 | Acknowledge report for the last item |
| ctl_ack_nack | input | 1 | Report is a NACK |
| ctl_stop | output | 1 | Issue stop and release the bus (pulse) |

## Verification
The reply builder is driven with requests that vary every mirrored field. These include a LUN-bit-heavy byte 0 whose netFn increment wraps to zero, odd and even return addresses, and frames padded past the five-byte header. Between them they separate each header field, the LUN clearing, and the two checksums from one another. Further directed runs cover a NACK on the address and a NACK mid-frame, a controller stall with ready held low, and a grant delayed after the request. A four-byte frame, a write spilling past the receive depth, and a second request arriving while a reply is pending complete the set: one must not reply, one must not overflow silently, and one must reply from the first request only, then from the stored second one on a bare stop.

// File: rtl/ipmb_resp_pkg.sv
package ipmb_resp_pkg;

  localparam int RESP_BYTES = 10;
  localparam int HDR_BYTES  = 5;
  localparam int IDX_W      = $clog2(RESP_BYTES);

  localparam logic [7:0] COMPL_OK  = 8'h00;
  localparam logic [7:0] PAYLOAD_A = 8'h55;
  localparam logic [7:0] PAYLOAD_B = 8'h00;

  typedef struct packed {
    logic [7:0] netfn_lun;
    logic [7:0] req_addr;
    logic [7:0] seq_lun;
    logic [7:0] cmd;
  } req_hdr_t;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_REQ,
    TX_SEND,
    TX_WAIT,
    TX_STOP
  } tx_state_e;

endpackage

// File: rtl/ipmb_rx_capture.sv
module ipmb_rx_capture
  import ipmb_resp_pkg::*;
#(
  parameter int RX_DEPTH = 512,
  parameter int MIN_LEN  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_wr,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output req_hdr_t   hdr,
  output logic       frame_ok,
  output logic       overflow
);

  localparam int CW = $clog2(RX_DEPTH + 1);

  logic [CW-1:0] cnt_q;
  req_hdr_t      hdr_q;
  logic          ovf_q;
  logic          room;

  assign room = (cnt_q < CW'(RX_DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hdr_q <= '0;
      ovf_q <= 1'b0;
    end else if (start_wr) begin
      cnt_q <= '0;
      hdr_q <= '0;
      ovf_q <= 1'b0;
    end else if (wr_valid) begin
      if (room) begin
        cnt_q <= cnt_q + 1'b1;
        case (cnt_q)
          CW'(0): hdr_q.netfn_lun <= wr_data;
          CW'(2): hdr_q.req_addr  <= wr_data;
          CW'(3): hdr_q.seq_lun   <= wr_data;
          CW'(4): hdr_q.cmd       <= wr_data;
          default: ;
        endcase
      end else begin
        ovf_q <= 1'b1;
      end
    end
  end

  assign hdr      = hdr_q;
  assign frame_ok = (cnt_q >= CW'(MIN_LEN));
  assign overflow = ovf_q;

endmodule

// File: rtl/ipmb_frame_builder.sv
module ipmb_frame_builder
  import ipmb_resp_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h16
) (
  input  req_hdr_t                        hdr,
  output logic [RESP_BYTES-1:0][7:0]      frame
);

  logic [7:0] rq_byte;
  logic [7:0] nf_byte;
  logic [7:0] hdr_sum;
  logic [7:0] body_sum;
  logic [RESP_BYTES-1:0][7:0] pre;

  always_comb begin
    rq_byte = hdr.req_addr;
    nf_byte = {hdr.netfn_lun[7:2] + 6'd1, 2'b00};
    hdr_sum = 8'd0 - rq_byte - nf_byte;

    pre      = '0;
    pre[0]   = rq_byte;
    pre[1]   = nf_byte;
    pre[2]   = hdr_sum;
    pre[3]   = {1'b0, OWN_ADDR};
    pre[4]   = {hdr.seq_lun[7:2], 2'b00};
    pre[5]   = hdr.cmd;
    pre[6]   = COMPL_OK;
    pre[7]   = PAYLOAD_A;
    pre[8]   = PAYLOAD_B;

    body_sum = '0;
    for (int i = 0; i < RESP_BYTES - 1; i++) begin
      body_sum = body_sum + pre[i];
    end

    frame                 = pre;
    frame[RESP_BYTES-1]   = 8'd0 - body_sum;
  end

endmodule

// File: rtl/ipmb_tx_sequencer.sv
module ipmb_tx_sequencer
  import ipmb_resp_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       launch,
  input  logic [RESP_BYTES-1:0][7:0] frame,
  input  logic                       bus_grant,
  input  logic                       ctl_ready,
  input  logic                       ack_valid,
  input  logic                       ack_nack,
  output logic                       idle,
  output logic                       bus_req,
  output logic                       ctl_valid,
  output logic                       ctl_first,
  output logic [7:0]                 ctl_data,
  output logic                       ctl_stop
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RESP_BYTES - 1);

  tx_state_e                 st_q;
  logic [IDX_W-1:0]          idx_q;
  logic [RESP_BYTES-1:0][7:0] buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      idx_q <= '0;
      buf_q <= '0;
    end else begin
      case (st_q)
        TX_IDLE: if (launch) begin
          buf_q <= frame;
          idx_q <= '0;
          st_q  <= TX_REQ;
        end
        TX_REQ: if (bus_grant) st_q <= TX_SEND;
        TX_SEND: if (ctl_ready) st_q <= TX_WAIT;
        TX_WAIT: if (ack_valid) begin
          if (ack_nack || idx_q == LAST_IDX) begin
            st_q <= TX_STOP;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= TX_SEND;
          end
        end
        TX_STOP: begin
          st_q  <= TX_IDLE;
          idx_q <= '0;
          buf_q <= '0;
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assign idle      = (st_q == TX_IDLE);
  assign bus_req   = (st_q != TX_IDLE);
  assign ctl_valid = (st_q == TX_SEND);
  assign ctl_first = (st_q == TX_SEND) && (idx_q == '0);
  assign ctl_data  = (idx_q == '0) ? {1'b0, buf_q[0][7:1]} : buf_q[idx_q];
  assign ctl_stop  = (st_q == TX_STOP);

endmodule

// File: rtl/ipmb_echo_responder.sv
module ipmb_echo_responder
  import ipmb_resp_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h16,
  parameter int         RX_DEPTH = 512,
  parameter int         MIN_LEN  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tgt_start_wr,
  input  logic       tgt_wr_valid,
  input  logic [7:0] tgt_wr_data,
  output logic       tgt_wr_ready,
  input  logic       tgt_stop,
  input  logic       tgt_rd_req,
  output logic       tgt_rd_valid,
  output logic [7:0] tgt_rd_data,
  output logic       rx_overflow,
  output logic       ctl_bus_req,
  input  logic       ctl_bus_grant,
  output logic       ctl_valid,
  output logic       ctl_first,
  output logic [7:0] ctl_data,
  input  logic       ctl_ready,
  input  logic       ctl_ack_valid,
  input  logic       ctl_ack_nack,
  output logic       ctl_stop
);

  req_hdr_t                   hdr;
  logic                       frame_ok;
  logic                       seq_idle;
  logic                       launch;
  logic [RESP_BYTES-1:0][7:0] frame;
  logic                       rd_valid_q;

  ipmb_rx_capture #(
    .RX_DEPTH (RX_DEPTH),
    .MIN_LEN  (MIN_LEN)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_wr (tgt_start_wr),
    .wr_valid (tgt_wr_valid),
    .wr_data  (tgt_wr_data),
    .hdr      (hdr),
    .frame_ok (frame_ok),
    .overflow (rx_overflow)
  );

  ipmb_frame_builder #(
    .OWN_ADDR (OWN_ADDR)
  ) u_build (
    .hdr   (hdr),
    .frame (frame)
  );

  assign launch = tgt_stop && frame_ok && seq_idle;

  ipmb_tx_sequencer u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .frame     (frame),
    .bus_grant (ctl_bus_grant),
    .ctl_ready (ctl_ready),
    .ack_valid (ctl_ack_valid),
    .ack_nack  (ctl_ack_nack),
    .idle      (seq_idle),
    .bus_req   (ctl_bus_req),
    .ctl_valid (ctl_valid),
    .ctl_first (ctl_first),
    .ctl_data  (ctl_data),
    .ctl_stop  (ctl_stop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= tgt_rd_req;
  end

  assign tgt_rd_valid = rd_valid_q;
  assign tgt_rd_data  = 8'hFF;
  assign tgt_wr_ready = 1'b1;

endmodule

// File: rtl/ipmb_echo_responder_chk.sv
module ipmb_echo_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tgt_start_wr,
  input logic       tgt_rd_req,
  input logic       tgt_rd_valid,
  input logic [7:0] tgt_rd_data,
  input logic       rx_overflow,
  input logic       ctl_bus_req,
  input logic       ctl_valid,
  input logic       ctl_first,
  input logic [7:0] ctl_data,
  input logic       ctl_ready,
  input logic       ctl_stop
);

  assert_read_ff_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rd_req |=> (tgt_rd_valid && tgt_rd_data == 8'hFF));

  assert_valid_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |-> ctl_bus_req);

  assert_addr_bit7_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && ctl_first) |-> !ctl_data[7]);

  assert_stop_no_item_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_stop |-> !ctl_valid);

  assert_release_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_stop |=> (!ctl_bus_req && !ctl_stop));

  assert_ovf_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overflow && !tgt_start_wr) |=> rx_overflow);

  assert_hold_on_stall_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && !ctl_ready) |=> (ctl_valid && $stable(ctl_data) && $stable(ctl_first)));

endmodule

bind ipmb_echo_responder ipmb_echo_responder_chk chk_i (.*);

// File: tb/ipmb_echo_responder_tb_top.sv
module ipmb_echo_responder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] OWN = 8'h16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tgt_start_wr = 1'b0;
  logic       tgt_wr_valid = 1'b0;
  logic [7:0] tgt_wr_data = 8'h00;
  logic       tgt_wr_ready;
  logic       tgt_stop = 1'b0;
  logic       tgt_rd_req = 1'b0;
  logic       tgt_rd_valid;
  logic [7:0] tgt_rd_data;
  logic       rx_overflow;
  logic       ctl_bus_req;
  logic       ctl_bus_grant = 1'b0;
  logic       ctl_valid;
  logic       ctl_first;
  logic [7:0] ctl_data;
  logic       ctl_ready = 1'b1;
  logic       ctl_ack_valid = 1'b0;
  logic       ctl_ack_nack = 1'b0;
  logic       ctl_stop;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] got   [16];
  logic       gfirst[16];
  int         nb;
  logic       saw_stop;

  // {extra_len, rx0, rx1, rx2, rx3, rx4}
  localparam logic [47:0] VEC [5] = '{
    48'h00_18_2C_20_84_01,
    48'h03_FF_2C_41_FF_7E,
    48'h00_30_2C_A2_13_00,
    48'h02_06_2C_FF_02_C3,
    48'h01_2E_2C_00_FC_FF
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  ipmb_echo_responder dut_i (
    .clk(clk), .rst_n(rst_n),
    .tgt_start_wr(tgt_start_wr), .tgt_wr_valid(tgt_wr_valid),
    .tgt_wr_data(tgt_wr_data), .tgt_wr_ready(tgt_wr_ready),
    .tgt_stop(tgt_stop), .tgt_rd_req(tgt_rd_req),
    .tgt_rd_valid(tgt_rd_valid), .tgt_rd_data(tgt_rd_data),
    .rx_overflow(rx_overflow), .ctl_bus_req(ctl_bus_req),
    .ctl_bus_grant(ctl_bus_grant), .ctl_valid(ctl_valid),
    .ctl_first(ctl_first), .ctl_data(ctl_data), .ctl_ready(ctl_ready),
    .ctl_ack_valid(ctl_ack_valid), .ctl_ack_nack(ctl_ack_nack),
    .ctl_stop(ctl_stop)
  );

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    summary_and_end();
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Reference reply built from the requirement text (R5..R8)
  function automatic logic [7:0] ref_byte(input logic [39:0] rq, input int i);
    logic [7:0] r0, r2, r3, r4;
    logic [7:0] b [10];
    logic [7:0] s;
    r0 = rq[39:32]; r2 = rq[23:16]; r3 = rq[15:8]; r4 = rq[7:0];
    b[0] = r2;
    b[1] = {r0[7:2] + 6'd1, 2'b00};
    b[2] = 8'd0 - b[0] - b[1];
    b[3] = OWN;
    b[4] = r3 & 8'hFC;
    b[5] = r4;
    b[6] = 8'h00; b[7] = 8'h55; b[8] = 8'h00;
    s = 8'd0;
    for (int k = 0; k < 9; k++) s = s + b[k];
    b[9] = 8'd0 - s;
    if (i == 0) return {1'b0, b[0][7:1]};
    return b[i];
  endfunction

  task automatic put_byte(input logic [7:0] d);
    @(negedge clk); tgt_wr_valid = 1'b1; tgt_wr_data = d;
    @(negedge clk); tgt_wr_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); tgt_start_wr = 1'b1;
    @(negedge clk); tgt_start_wr = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); tgt_stop = 1'b1;
    @(negedge clk); tgt_stop = 1'b0;
  endtask

  task automatic write_frame(input logic [39:0] rq, input int extra, input logic stop);
    pulse_start();
    for (int k = 0; k < 5; k++) put_byte(rq[39 - 8*k -: 8]);
    for (int k = 0; k < extra; k++) put_byte(8'hA5);
    if (stop) pulse_stop();
  endtask

  task automatic serve(input int nack_idx, input int stall);
    int pend;
    int left;
    logic [7:0] held;
    nb = 0; saw_stop = 1'b0; pend = 0; left = stall; held = 8'h00;
    ctl_bus_grant = 1'b1;
    for (int cyc = 0; cyc < 400 && !saw_stop; cyc++) begin
      @(negedge clk);
      ctl_ack_valid = 1'b0; ctl_ack_nack = 1'b0;
      if (ctl_stop) begin
        saw_stop = 1'b1;
      end else if (ctl_valid) begin
        if (left > 0) begin
          if (left != stall) check(ctl_data == held, "R13 held item", ctl_data, held);
          held = ctl_data; ctl_ready = 1'b0; left--;
        end else begin
          ctl_ready = 1'b1;
          got[nb] = ctl_data; gfirst[nb] = ctl_first; nb++; pend = 1;
        end
      end else if (pend != 0) begin
        ctl_ack_valid = 1'b1;
        ctl_ack_nack  = (nb - 1 == nack_idx);
        pend = 0;
      end
    end
    ctl_bus_grant = 1'b0; ctl_ready = 1'b1;
    check(saw_stop, "R10 stop pulse", saw_stop, 1);
    @(negedge clk);
    check(!ctl_bus_req, "R10 bus released", ctl_bus_req, 0);
  endtask

  task automatic compare_reply(input logic [39:0] rq, input string tag);
    check(nb == 10, tag, nb, 10);
    for (int i = 0; i < 10 && i < nb; i++) begin
      check(gfirst[i] == (i == 0), "R5 first flag", gfirst[i], (i == 0));
      check(got[i] == ref_byte(rq, i),
            (i == 0) ? "R5 address" : (i < 3) ? "R6 header" : (i < 9) ? "R7 body" : "R8 checksum",
            got[i], ref_byte(rq, i));
    end
  endtask

  task automatic expect_quiet(input int cycles, input string tag);
    logic seen;
    seen = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (ctl_bus_req || ctl_valid) seen = 1'b1;
    end
    check(!seen, tag, seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check(!ctl_bus_req && !ctl_valid && !ctl_stop, "R10 reset idle", ctl_bus_req, 0);
    check(!rx_overflow, "R12 reset flag", rx_overflow, 0);
    check(tgt_wr_ready, "R11 write ready", tgt_wr_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: read returns 0xFF
    tgt_rd_req = 1'b1;
    @(negedge clk); tgt_rd_req = 1'b0;
    check(tgt_rd_valid && tgt_rd_data == 8'hFF, "R2 read data", tgt_rd_data, 8'hFF);

    // table walk: main function (R1, R5..R8)
    for (int v = 0; v < 5; v++) begin
      write_frame(VEC[v][39:0], int'(VEC[v][47:40]), 1'b1);
      serve(-1, 0);
      compare_reply(VEC[v][39:0], "R1 reply length");
    end

    // R3 + R1: short frame after a full one, count restarted
    pulse_start();
    for (int k = 0; k < 4; k++) put_byte(8'h11);
    pulse_stop();
    expect_quiet(20, "R3 short frame silent");

    // R4: grant withheld, request held, no items
    write_frame(VEC[0][39:0], 0, 1'b1);
    begin
      logic bad;
      bad = 1'b0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (!ctl_bus_req || ctl_valid) bad = 1'b1;
      end
      check(!bad, "R4 wait for grant", bad, 0);
    end
    // R11: second request while pending
    write_frame(VEC[2][39:0], 0, 1'b1);
    serve(-1, 0);
    compare_reply(VEC[0][39:0], "R11 first reply only");
    expect_quiet(20, "R11 no second reply");
    pulse_stop();
    serve(-1, 0);
    compare_reply(VEC[2][39:0], "R11 stored frame");

    // R9: nack on address
    write_frame(VEC[1][39:0], 0, 1'b1);
    serve(0, 0);
    check(nb == 1, "R9 nack on address", nb, 1);
    // R9: nack on data byte 4
    write_frame(VEC[3][39:0], 0, 1'b1);
    serve(4, 0);
    check(nb == 5, "R9 nack mid frame", nb, 5);
    // R10: restart from address after abort; R13 stall
    write_frame(VEC[4][39:0], 0, 1'b1);
    serve(-1, 3);
    compare_reply(VEC[4][39:0], "R13 reply under stall");

    // R12: overflow
    pulse_start();
    for (int k = 0; k < 512; k++) begin
      @(negedge clk); tgt_wr_valid = 1'b1; tgt_wr_data = 8'(k);
    end
    @(negedge clk); tgt_wr_valid = 1'b0;
    check(!rx_overflow, "R12 full not overflow", rx_overflow, 0);
    put_byte(8'h99);
    check(rx_overflow, "R12 overflow set", rx_overflow, 1);
    repeat (3) @(negedge clk);
    check(rx_overflow, "R12 overflow held", rx_overflow, 1);
    pulse_start();
    check(!rx_overflow, "R1 start clears overflow", rx_overflow, 0);

    summary_and_end();
  end

endmodule